// File: doc/BRIEF.md
# Interrupt Attribute Bank with Two Security States

This block stores the per-interrupt configuration that an interrupt distributor needs. For every interrupt ID it keeps an enable, a group bit, a group-modifier bit, a priority and a trigger type. It also holds one global control word. Every access on its register bus carries a non-secure flag. The bank filters each access against the security rules, so non-secure software can only see and change interrupts that belong to it.

The delivery logic reads the stored attributes directly from flat output vectors. Each interrupt's group arrives already decoded into a 2-bit class. A global flag switches the bank from two security states to a single one. Once set, that flag stays set until reset.

Software-generated IDs (the lowest IDs) are always edge-triggered. Message-based IDs (the highest IDs) have a fixed group.

Top module: `irqattr_bank`

## Requirements
- R1: After reset all enables, group bits, modifier bits and priorities are 0, the control word is 0 and rvalid is 0. Trigger bits reset to level (0), except for software-generated IDs, which read edge (1).
- R2: A read request (req=1, wr=0) returns rdata with rvalid=1 in the next cycle, and rvalid is 0 in any other cycle. A word index beyond the implemented IDs reads 0. The word address splits as bits [9:6] = region (0 control, 1 group, 2 modifier, 3 set-enable, 4 clear-enable, 5 trigger, 6 priority) and bits [5:0] = word index.
- R3: Control bit 3 selects single-security-state mode. Writing 1 to it sets it. No write clears it; only reset does.
- R4: Outside single-state mode, the exported 2-bit group code is decoded from the group bit and modifier bit as follows:
  - group=1 gives 2 (non-secure group 1).
  - group=0 with modifier=1 gives 1 (secure group 1).
  - group=0 with modifier=0 gives 0 (group 0).
- R4 (single-state mode): group=0 gives code 0 and group=1 gives code 3 (the one group 1). The modifier reads 0 and ignores writes.
- R5: In two-state mode, a non-secure access to the group or modifier region reads 0 and its write is dropped.
- R6: In two-state mode, a non-secure access to the set-enable, clear-enable, trigger or priority regions affects only IDs whose code is 2. All other IDs read 0 for that access and keep their value on a write.
- R7: Writing 1 in the set-enable region enables that ID, and writing 1 in the clear-enable region disables it. Zero bits have no effect, and both regions read the current enables.
- R8: The bit regions hold 32 IDs per word, with ID 32w+b at bit b of word w. Priorities are 8-bit fields, four per word, with ID 4w+k at bits [8k+7:8k]. Only the top PRIO_BITS bits of a priority are stored; lower bits read 0 and are exported as 0. Priority 0x00 is the most urgent.
- R9: Trigger bit 1 means edge and 0 means level. Software-generated IDs (below NUM_SGI) always read 1 and ignore writes.
- R10: IDs at or above MSG_BASE read group=1 and modifier=0, ignore writes to either, and export code 2 in two-state mode or 3 in single-state mode.
- R11: In the control word, bit 0 enables group 0 and bit 1 enables secure group 1 (the single group 1 in single-state mode). Bit 2 enables non-secure group 1. In two-state mode a non-secure access sees and writes only bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request |
| wr | input | 1 | 1 = write, 0 = read |
| ns | input | 1 | 1 = non-secure access |
| addr | input | ADDR_W | Word address: region in the top 4 bits, word index below |
| wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid |
| rdata | output | 32 | Read data |
| grp_en_g0 | output | 1 | Group 0 enable |
| grp_en_g1s | output | 1 | Secure (or single) group 1 enable |
| grp_en_g1ns | output | 1 | Non-secure group 1 enable |
| single_state | output | 1 | Single-security-state mode |
| irq_en | output | NUM_IRQ | Per-ID enable |
| irq_grp | output | 2*NUM_IRQ | Per-ID group code, ID i at [2i+1:2i] |
| irq_prio | output | 8*NUM_IRQ | Per-ID priority, ID i at [8i+7:8i] |
| irq_edge | output | NUM_IRQ | Per-ID trigger, 1 = edge |

## Verification
The bench uses 64 IDs, 16 software-generated IDs, message-based IDs from 48 and 5 priority bits. With these values the bit regions span two words. The second word holds ordinary IDs in its lower half and forced-group IDs in its upper half, so word-boundary and forced-group rules show up in a single read. Trimming to 5 priority bits makes the read-as-zero low bits visible with all-ones and mixed patterns. The run starts in two-state mode, enters single-state mode, and ends with a reset to show the flag clears only that way.

// File: rtl/irqattr_pkg.sv
package irqattr_pkg;

  typedef enum logic [1:0] {
    GRP_G0     = 2'd0,
    GRP_G1_SEC = 2'd1,
    GRP_G1_NS  = 2'd2,
    GRP_G1_ONE = 2'd3
  } grp_code_t;

  localparam logic [3:0] RG_CTRL  = 4'd0;
  localparam logic [3:0] RG_GROUP = 4'd1;
  localparam logic [3:0] RG_MOD   = 4'd2;
  localparam logic [3:0] RG_SETEN = 4'd3;
  localparam logic [3:0] RG_CLREN = 4'd4;
  localparam logic [3:0] RG_TRIG  = 4'd5;
  localparam logic [3:0] RG_PRIO  = 4'd6;

  // Group class from the stored bits and the global mode.
  function automatic grp_code_t grp_decode(input logic grp, input logic modf,
                                           input logic single);
    if (single) return grp ? GRP_G1_ONE : GRP_G0;
    if (grp)    return GRP_G1_NS;
    return modf ? GRP_G1_SEC : GRP_G0;
  endfunction

  // Whether a non-secure access may see an interrupt of this class.
  function automatic logic ns_visible(input grp_code_t c, input logic single);
    return single || (c == GRP_G1_NS);
  endfunction

  // Keep only the implemented upper priority bits.
  function automatic logic [7:0] prio_trim(input logic [7:0] p, input int bits);
    logic [7:0] m;
    m = 8'hFF << (8 - bits);
    return p & m;
  endfunction

endpackage

// File: rtl/irqattr_ctrl.sv
module irqattr_ctrl
  import irqattr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       ns,
  input  logic [3:0] wbits,
  output logic       g0_en,
  output logic       g1s_en,
  output logic       g1ns_en,
  output logic       single,
  output logic [3:0] rd_view
);

  logic ns_limited;
  assign ns_limited = ns && !single;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g0_en   <= 1'b0;
      g1s_en  <= 1'b0;
      g1ns_en <= 1'b0;
      single  <= 1'b0;
    end else if (wr_ctrl) begin
      g1ns_en <= wbits[2];
      if (!ns_limited) begin
        g0_en  <= wbits[0];
        g1s_en <= wbits[1];
        if (wbits[3]) single <= 1'b1;
      end
    end
  end

  assign rd_view = ns_limited ? {1'b0, g1ns_en, 2'b00}
                              : {single, g1ns_en, g1s_en, g0_en};

endmodule

// File: rtl/irqattr_slot.sv
module irqattr_slot
  import irqattr_pkg::*;
#(
  parameter bit IS_SGI    = 1'b0,
  parameter bit IS_MSG    = 1'b0,
  parameter int PRIO_BITS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       single,
  input  logic       ns,
  input  logic       wr_grp,
  input  logic       wr_mod,
  input  logic       wr_set,
  input  logic       wr_clr,
  input  logic       wr_trig,
  input  logic       wr_prio,
  input  logic       wbit,
  input  logic [7:0] wprio,
  output logic       en,
  output logic       grp_vis,
  output logic       mod_vis,
  output logic       edge_trig,
  output logic [7:0] prio,
  output grp_code_t  code,
  output logic       ns_ok
);

  logic grp_q, mod_q, trig_q;
  logic sec_cfg_ok, attr_ok;

  assign grp_vis    = IS_MSG ? 1'b1 : grp_q;
  assign mod_vis    = (IS_MSG || single) ? 1'b0 : mod_q;
  assign code       = grp_decode(grp_vis, mod_vis, single);
  assign ns_ok      = ns_visible(code, single);
  assign sec_cfg_ok = single || !ns;
  assign attr_ok    = !ns || ns_ok;
  assign edge_trig  = IS_SGI ? 1'b1 : trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= 1'b0;
      mod_q  <= 1'b0;
      en     <= 1'b0;
      trig_q <= 1'b0;
      prio   <= 8'h00;
    end else begin
      if (wr_grp && sec_cfg_ok && !IS_MSG) grp_q <= wbit;
      if (wr_mod && !ns && !single && !IS_MSG) mod_q <= wbit;
      if (attr_ok) begin
        if (wr_set && wbit)      en <= 1'b1;
        else if (wr_clr && wbit) en <= 1'b0;
        if (wr_trig && !IS_SGI)  trig_q <= wbit;
        if (wr_prio)             prio <= prio_trim(wprio, PRIO_BITS);
      end
    end
  end

endmodule

// File: rtl/irqattr_rdmux.sv
module irqattr_rdmux
  import irqattr_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int IDX_W   = 6
) (
  input  logic [3:0]           region,
  input  logic [IDX_W-1:0]     index,
  input  logic                 ns,
  input  logic                 single,
  input  logic [3:0]           ctrl_view,
  input  logic [NUM_IRQ-1:0]   en,
  input  logic [NUM_IRQ-1:0]   grp_vis,
  input  logic [NUM_IRQ-1:0]   mod_vis,
  input  logic [NUM_IRQ-1:0]   trig,
  input  logic [8*NUM_IRQ-1:0] prio,
  input  logic [NUM_IRQ-1:0]   ns_ok,
  output logic [31:0]          rword
);

  localparam int BIT_WORDS  = (NUM_IRQ + 31) / 32;
  localparam int PRIO_WORDS = (NUM_IRQ + 3) / 4;

  logic ns_limited;
  logic [NUM_IRQ-1:0]        vis;
  logic [BIT_WORDS*32-1:0]   en_pad, grp_pad, mod_pad, trig_pad;
  logic [PRIO_WORDS*32-1:0]  prio_pad;

  assign ns_limited = ns && !single;
  assign vis        = ns_limited ? ns_ok : '1;

  always_comb begin
    en_pad   = '0;
    grp_pad  = '0;
    mod_pad  = '0;
    trig_pad = '0;
    prio_pad = '0;
    en_pad[NUM_IRQ-1:0]   = en & vis;
    trig_pad[NUM_IRQ-1:0] = trig & vis;
    grp_pad[NUM_IRQ-1:0]  = ns_limited ? '0 : grp_vis;
    mod_pad[NUM_IRQ-1:0]  = ns_limited ? '0 : mod_vis;
    for (int i = 0; i < NUM_IRQ; i++)
      prio_pad[8*i +: 8] = vis[i] ? prio[8*i +: 8] : 8'h00;
  end

  always_comb begin
    rword = '0;
    case (region)
      RG_CTRL:  if (index == '0) rword = {28'd0, ctrl_view};
      RG_GROUP: if (int'(index) < BIT_WORDS) rword = grp_pad[32*int'(index) +: 32];
      RG_MOD:   if (int'(index) < BIT_WORDS) rword = mod_pad[32*int'(index) +: 32];
      RG_SETEN,
      RG_CLREN: if (int'(index) < BIT_WORDS) rword = en_pad[32*int'(index) +: 32];
      RG_TRIG:  if (int'(index) < BIT_WORDS) rword = trig_pad[32*int'(index) +: 32];
      RG_PRIO:  if (int'(index) < PRIO_WORDS) rword = prio_pad[32*int'(index) +: 32];
      default:  rword = '0;
    endcase
  end

endmodule

// File: rtl/irqattr_bank.sv
module irqattr_bank
  import irqattr_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_SGI   = 16,
  parameter int MSG_BASE  = 48,
  parameter int PRIO_BITS = 5,
  parameter int ADDR_W    = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 wr,
  input  logic                 ns,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic                 rvalid,
  output logic [31:0]          rdata,
  output logic                 grp_en_g0,
  output logic                 grp_en_g1s,
  output logic                 grp_en_g1ns,
  output logic                 single_state,
  output logic [NUM_IRQ-1:0]   irq_en,
  output logic [2*NUM_IRQ-1:0] irq_grp,
  output logic [8*NUM_IRQ-1:0] irq_prio,
  output logic [NUM_IRQ-1:0]   irq_edge
);

  localparam int IDX_W = ADDR_W - 4;

  // Named access events, also observed by the checker.
  logic              acc_rd, acc_wr;
  logic [3:0]        region;
  logic [IDX_W-1:0]  windex;
  logic              rd_prio_q;
  logic              wr_ctrl;
  logic [3:0]        ctrl_view;
  logic [31:0]       rword;
  logic [NUM_IRQ-1:0] grp_vis_v, mod_vis_v, ns_ok_v;

  assign acc_rd  = req && !wr;
  assign acc_wr  = req && wr;
  assign region  = addr[ADDR_W-1 -: 4];
  assign windex  = addr[IDX_W-1:0];
  assign wr_ctrl = acc_wr && (region == RG_CTRL) && (windex == '0);

  irqattr_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .ns      (ns),
    .wbits   (wdata[3:0]),
    .g0_en   (grp_en_g0),
    .g1s_en  (grp_en_g1s),
    .g1ns_en (grp_en_g1ns),
    .single  (single_state),
    .rd_view (ctrl_view)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_slot
    localparam int BW = i / 32;
    localparam int BB = i % 32;
    localparam int PW = i / 4;
    localparam int PB = i % 4;
    logic      hit_bit, hit_prio;
    grp_code_t code;
    assign hit_bit  = (windex == IDX_W'(BW));
    assign hit_prio = (windex == IDX_W'(PW));

    irqattr_slot #(
      .IS_SGI    (i < NUM_SGI),
      .IS_MSG    (i >= MSG_BASE),
      .PRIO_BITS (PRIO_BITS)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .single    (single_state),
      .ns        (ns),
      .wr_grp    (acc_wr && region == RG_GROUP && hit_bit),
      .wr_mod    (acc_wr && region == RG_MOD   && hit_bit),
      .wr_set    (acc_wr && region == RG_SETEN && hit_bit),
      .wr_clr    (acc_wr && region == RG_CLREN && hit_bit),
      .wr_trig   (acc_wr && region == RG_TRIG  && hit_bit),
      .wr_prio   (acc_wr && region == RG_PRIO  && hit_prio),
      .wbit      (wdata[BB]),
      .wprio     (wdata[8*PB +: 8]),
      .en        (irq_en[i]),
      .grp_vis   (grp_vis_v[i]),
      .mod_vis   (mod_vis_v[i]),
      .edge_trig (irq_edge[i]),
      .prio      (irq_prio[8*i +: 8]),
      .code      (code),
      .ns_ok     (ns_ok_v[i])
    );
    assign irq_grp[2*i +: 2] = code;
  end

  irqattr_rdmux #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_rdmux (
    .region    (region),
    .index     (windex),
    .ns        (ns),
    .single    (single_state),
    .ctrl_view (ctrl_view),
    .en        (irq_en),
    .grp_vis   (grp_vis_v),
    .mod_vis   (mod_vis_v),
    .trig      (irq_edge),
    .prio      (irq_prio),
    .ns_ok     (ns_ok_v),
    .rword     (rword)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid    <= 1'b0;
      rdata     <= '0;
      rd_prio_q <= 1'b0;
    end else begin
      rvalid    <= acc_rd;
      rd_prio_q <= acc_rd && (region == RG_PRIO);
      if (acc_rd) rdata <= rword;
    end
  end

endmodule

// File: rtl/irqattr_chk.sv
module irqattr_chk
  import irqattr_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_rd,
  input logic               acc_wr,
  input logic               ns,
  input logic [3:0]         region,
  input logic               rvalid,
  input logic [31:0]        rdata,
  input logic               rd_prio_q,
  input logic               single_state,
  input logic               grp_en_g0,
  input logic               grp_en_g1s,
  input logic [NUM_IRQ-1:0] irq_en
);

  logic [31:0] low_mask;
  assign low_mask = ~{4{prio_trim(8'hFF, PRIO_BITS)}};

  p_single_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    single_state |=> single_state);

  p_ns_ctrl_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && ns && !single_state && region == RG_CTRL)
      |=> ($stable(grp_en_g0) && $stable(grp_en_g1s) && $stable(single_state)));

  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rvalid);

  p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> !rvalid);

  p_ns_group_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && ns && !single_state && (region == RG_GROUP || region == RG_MOD))
      |=> (rdata == 32'd0));

  p_prio_lsb_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rd_prio_q) |-> ((rdata & low_mask) == 32'd0));

  p_read_no_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> $stable(irq_en));

endmodule

bind irqattr_bank irqattr_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_rd       (acc_rd),
  .acc_wr       (acc_wr),
  .ns           (ns),
  .region       (region),
  .rvalid       (rvalid),
  .rdata        (rdata),
  .rd_prio_q    (rd_prio_q),
  .single_state (single_state),
  .grp_en_g0    (grp_en_g0),
  .grp_en_g1s   (grp_en_g1s),
  .irq_en       (irq_en)
);

// File: tb/sim_irqattr_bank.sv
module sim_irqattr_bank;

  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, wr = 1'b0, ns = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic          rvalid;
  logic [31:0]   rdata;
  logic          g0, g1s, g1ns, single;
  logic [N-1:0]  irq_en, irq_edge;
  logic [2*N-1:0] irq_grp;
  logic [8*N-1:0] irq_prio;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  irqattr_bank #(.NUM_IRQ(N), .NUM_SGI(16), .MSG_BASE(48), .PRIO_BITS(5), .ADDR_W(10)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .ns(ns), .addr(addr), .wdata(wdata),
    .rvalid(rvalid), .rdata(rdata), .grp_en_g0(g0), .grp_en_g1s(g1s),
    .grp_en_g1ns(g1ns), .single_state(single), .irq_en(irq_en), .irq_grp(irq_grp),
    .irq_prio(irq_prio), .irq_edge(irq_edge)
  );

  function automatic logic [9:0] A(input int rg, input int idx);
    return {4'(rg), 6'(idx)};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic n, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = w; ns = n; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
  endtask

  task automatic wreg(input logic n, input logic [9:0] a, input logic [31:0] d);
    bus(1'b1, n, a, d);
  endtask

  // Driver: push the expected word into the scoreboard, then issue the read.
  task automatic rexp(input logic n, input logic [9:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus(1'b0, n, a, 32'd0);
  endtask

  // Monitor: compare each returned word with the oldest expectation.
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk(rdata, 32'hxxxxxxxx, "R2 unexpected rvalid");
      else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk({31'd0, rvalid}, 32'd0, "R1 rvalid after reset");
    chk(32'(irq_en), 32'd0, "R1 enables low word");
    chk(32'(irq_edge), 32'h0000FFFF, "R1 R9 edge bits");
    rexp(0, A(0,0), 32'h0, "R1 control word");
    rexp(0, A(5,0), 32'h0000FFFF, "R1 R9 trigger word0");
    rexp(0, A(5,1), 32'h0, "R1 trigger word1");
    rexp(0, A(6,0), 32'h0, "R1 priority word0");
    rexp(0, A(1,1), 32'hFFFF0000, "R10 forced group word1");
    rexp(0, A(2,1), 32'h0, "R10 modifier word1");
    chk(32'(irq_grp[2*5 +: 2]), 32'd0, "R1 R4 id5 code G0");

    // R4 decode in two-state mode
    wreg(0, A(1,0), 32'h000000F0);
    wreg(0, A(2,0), 32'h00000C30);
    chk(32'(irq_grp[2*4 +: 2]), 32'd2, "R4 id4 grp1 mod1");
    chk(32'(irq_grp[2*6 +: 2]), 32'd2, "R4 id6 grp1 mod0");
    chk(32'(irq_grp[2*10 +: 2]), 32'd1, "R4 id10 grp0 mod1");
    chk(32'(irq_grp[2*0 +: 2]), 32'd0, "R4 id0 grp0 mod0");

    // R5 non-secure group access
    rexp(1, A(1,0), 32'h0, "R5 ns group read");
    rexp(1, A(2,0), 32'h0, "R5 ns modifier read");
    wreg(1, A(1,0), 32'hFFFFFFFF);
    rexp(0, A(1,0), 32'h000000F0, "R5 ns group write dropped");

    // R6 R7 enables
    wreg(1, A(3,0), 32'hFFFFFFFF);
    rexp(0, A(3,0), 32'h000000F0, "R6 R7 ns set only ns ids");
    rexp(1, A(4,0), 32'h000000F0, "R6 R7 ns clear-region view");
    wreg(0, A(3,0), 32'h00010001);
    rexp(0, A(3,0), 32'h000100F1, "R7 secure set");
    wreg(0, A(4,0), 32'h00000000);
    rexp(0, A(4,0), 32'h000100F1, "R7 zero clear no effect");
    wreg(0, A(4,0), 32'h00000011);
    rexp(0, A(3,0), 32'h000100E0, "R7 clear ids 0 and 4");
    chk({31'd0, irq_en[16]}, 32'd1, "R7 id16 enable out");
    chk({31'd0, irq_en[4]},  32'd0, "R7 id4 enable out");

    // R8 priority
    wreg(0, A(6,1), 32'hFFFFFFFF);
    rexp(0, A(6,1), 32'hF8F8F8F8, "R8 trimmed all ones");
    chk(32'(irq_prio[8*4 +: 8]), 32'hF8, "R8 id4 priority out");
    wreg(1, A(6,0), 32'hAAAAAAAA);
    rexp(0, A(6,0), 32'h0, "R6 ns priority write to G0 dropped");
    wreg(1, A(6,1), 32'h12345678);
    rexp(0, A(6,1), 32'h10305078, "R6 R8 ns priority write to ns ids");

    // R9 trigger
    wreg(0, A(5,0), 32'h00000000);
    rexp(0, A(5,0), 32'h0000FFFF, "R9 sgi trigger ignores writes");
    wreg(0, A(5,0), 32'h00F00000);
    rexp(0, A(5,0), 32'h00F0FFFF, "R9 edge set ids 20-23");
    rexp(1, A(5,0), 32'h000000F0, "R6 ns trigger view");
    chk({31'd0, irq_edge[21]}, 32'd1, "R9 id21 edge out");

    // R10 message-based ids
    wreg(0, A(1,1), 32'h00000000);
    rexp(0, A(1,1), 32'hFFFF0000, "R10 group write ignored");
    wreg(0, A(2,1), 32'hFFFF0000);
    rexp(0, A(2,1), 32'h0, "R10 modifier write ignored");
    chk(32'(irq_grp[2*50 +: 2]), 32'd2, "R10 id50 code two-state");
    wreg(1, A(3,1), 32'hFFFF0000);
    rexp(0, A(3,1), 32'hFFFF0000, "R10 R6 ns enable of message ids");

    // R2 out-of-range
    rexp(0, A(1,5), 32'h0, "R2 group index out of range");
    rexp(0, A(6,20), 32'h0, "R2 priority index out of range");

    // R11 control word
    wreg(0, A(0,0), 32'h7);
    rexp(0, A(0,0), 32'h7, "R11 secure control write");
    rexp(1, A(0,0), 32'h4, "R11 ns control view");
    wreg(1, A(0,0), 32'h0);
    rexp(0, A(0,0), 32'h3, "R11 ns writes only bit 2");
    wreg(1, A(0,0), 32'h8);
    rexp(0, A(0,0), 32'h3, "R3 R11 ns cannot set single");
    chk({31'd0, single}, 32'd0, "R3 single out still 0");

    // R3 sticky single-state, single-mode rules
    wreg(0, A(0,0), 32'hB);
    rexp(0, A(0,0), 32'hB, "R3 single set");
    wreg(0, A(0,0), 32'h0);
    rexp(0, A(0,0), 32'h8, "R3 single sticky");
    chk({29'd0, g0, g1s, g1ns}, 32'd0, "R11 enables cleared in single mode");
    chk(32'(irq_grp[2*4 +: 2]), 32'd3, "R4 single id4 group 1");
    chk(32'(irq_grp[2*10 +: 2]), 32'd0, "R4 single modifier ignored");
    chk(32'(irq_grp[2*50 +: 2]), 32'd3, "R10 single id50 code");
    rexp(0, A(2,0), 32'h0, "R4 single modifier reads zero");
    rexp(1, A(1,0), 32'h000000F0, "R5 single ns group visible");
    wreg(1, A(6,0), 32'h00000008);
    rexp(1, A(6,0), 32'h00000008, "R8 single ns priority write");

    // R3 reset clears the flag
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk({31'd0, single}, 32'd0, "R3 reset clears single");
    rexp(0, A(0,0), 32'h0, "R3 R1 control after reset");
    repeat (3) @(negedge clk);
    chk(32'(exp_q.size()), 32'd0, "R2 all reads returned");
    finish_run();
  end

endmodule